// File: doc/BRIEF.md
# Keyed 22 kHz Tone Carrier Generator

This block makes a logic-level square-wave carrier near 22 kHz from the system clock. A half-period counter divides the clock down. Its terminal count is a parameter, derived by rounding the clock frequency over twice the tone frequency. The oscillator is gated from two sources. A continuous-tone control bit keeps the carrier running without a break. With that bit clear, an asynchronous keying pin switches the carrier on and off, so firmware can send pulse-width coded bursts.

Burst timing depends on how the oscillator starts and stops. A rising edge on the keying pin restarts the divider, so the first high half of every burst has full length. When keying ends, the current half-period completes before the carrier stops. A global enable, which is low in standby, silences the block on the next clock edge. A status output shows whether the oscillator is running.

Top module: `tone_carrier_top`

## Requirements
- R1: While running, every high and every low half of `tone_out` lasts exactly HALF clock cycles, where HALF = round(CLK_HZ / (2*TONE_HZ)). With the defaults this gives 2273 cycles at 100 MHz, and the duty cycle is 50%.
- R2: With `en`=1 and `tone_on`=1 the carrier runs without interruption, and `key_in` has no effect on `tone_out`.
- R3: With `en`=1 and `tone_on`=0, a 0-to-1 change of `key_in` makes `tone_out` go high 3 clock edges later (two synchronizer stages plus one state register). The first high half lasts a full HALF cycles.
- R4: When the synchronized key falls with `tone_on`=0, the running half-period still completes. The oscillator then stops, with `tone_out`=0 and `tone_active`=0. A key pulse of W cycles, W a multiple of HALF, produces exactly ceil(W / (2*HALF)) rising edges on `tone_out`.
- R5: While `en`=0, `tone_out` and `tone_active` are 0 from the next clock edge, and neither `key_in` nor `tone_on` can start the oscillator.
- R6: A rising edge of the synchronized key while the oscillator is still finishing a half-period with `tone_on`=0 restarts the carrier in phase: high for a full HALF cycles from that point.
- R7: While `rst_n` is low and right after it is released, `tone_out` and `tone_active` are 0.
- R8: `tone_active` is 1 exactly while the oscillator runs, and `tone_out` is never 1 while `tone_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Power enable; 0 means standby and silences the carrier |
| tone_on | input | 1 | Continuous-tone control bit; overrides the keying pin |
| key_in | input | 1 | Asynchronous keying pin for burst signalling |
| tone_out | output | 1 | Square-wave carrier |
| tone_active | output | 1 | High while the oscillator runs |

## Verification
On every cycle the embedded assertions check four things. Standby silences the outputs on the next edge. The carrier holds its level between half-period ticks. A start always opens with a high half. The counter stays in range, and a running oscillator only stops on a tick or when enable falls. Other properties depend on history across many cycles, and only the bench's scenarios can show them. These are the exact half-period length, the count of rising edges within a keyed burst, the three-edge start latency and the in-phase restart on a mid-half key edge. The bench covers them with a behavioural model compared on every clock and with width and edge counters.

// File: rtl/tone_pkg.sv
package tone_pkg;

  // Rounded half-period length in clock cycles.
  function automatic int unsigned half_count(input int unsigned clk_hz,
                                             input int unsigned tone_hz);
    int unsigned den;
    den = 2 * tone_hz;
    return (clk_hz + tone_hz) / den;
  endfunction

  // Width needed to hold values 0 .. n-1 (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/key_sync.sv
module key_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync,
  output logic d_rise
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its delayed copy
  logic [STAGES:0] chain;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];
  assign d_rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/half_divider.sv
module half_divider #(
  parameter int unsigned HALF = 2273
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = tone_pkg::cnt_width(HALF);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  assign tick = run & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clr || !run)     cnt <= '0;
    else if (tick)            cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  // R1: counter never runs past the half-period terminal value
  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R1: a restart always begins a fresh half-period from zero
  a_r1_clr_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/tone_ctrl.sv
module tone_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tone_on,
  input  logic key_s,
  input  logic key_rise,
  input  logic half_tick,
  output logic start_evt,
  output logic stop_evt,
  output logic run_q,
  output logic tone_out
);
  logic phase_q;
  logic want;

  assign want      = en & (tone_on | key_s);
  assign start_evt = want & (~run_q | (key_rise & ~tone_on));
  assign stop_evt  = run_q & ((~en) | (half_tick & ~want & ~start_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      phase_q <= 1'b0;
    end else if (!en) begin
      run_q   <= 1'b0;
      phase_q <= 1'b0;
    end else if (start_evt) begin
      run_q   <= 1'b1;
      phase_q <= 1'b1;
    end else if (run_q && half_tick) begin
      if (want) begin
        phase_q <= ~phase_q;
      end else begin
        run_q   <= 1'b0;
        phase_q <= 1'b0;
      end
    end
  end

  assign tone_out = phase_q;

  // R5: standby silences the carrier on the next edge
  a_r5_standby_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!tone_out && !run_q));

  // R3: every start opens with a high half
  a_r3_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (tone_out && run_q));

  // R2: continuous mode never drops a running oscillator
  a_r2_continuous: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tone_on && run_q) |=> run_q);

  // R4: a running oscillator only stops on a half-period boundary
  a_r4_stop_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && en && !half_tick) |=> run_q);

  // R1: level holds between half-period ticks
  a_r1_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && en && !half_tick && !start_evt) |=> $stable(tone_out));

  // R8: a stop event leaves both outputs low
  a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!run_q && !tone_out));
endmodule

// File: rtl/tone_carrier_top.sv
module tone_carrier_top #(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned TONE_HZ     = 22_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tone_on,
  input  logic key_in,
  output logic tone_out,
  output logic tone_active
);
  localparam int unsigned HALF = tone_pkg::half_count(CLK_HZ, TONE_HZ);

  logic key_s;
  logic key_rise;
  logic half_tick;
  logic start_evt;
  logic stop_evt;
  logic run_q;
  logic div_clr;

  key_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (key_in),
    .d_sync  (key_s),
    .d_rise  (key_rise)
  );

  assign div_clr = start_evt | ~en;

  half_divider #(.HALF(HALF)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .clr   (div_clr),
    .tick  (half_tick)
  );

  tone_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .tone_on   (tone_on),
    .key_s     (key_s),
    .key_rise  (key_rise),
    .half_tick (half_tick),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .run_q     (run_q),
    .tone_out  (tone_out)
  );

  assign tone_active = run_q;

  // R8: carrier is never high while the oscillator is idle
  a_r8_out_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    tone_out |-> tone_active);
endmodule

// File: tb/test_tone_carrier_top.sv
module test_tone_carrier_top;
  localparam int unsigned CLK_HZ  = 880_000;
  localparam int unsigned TONE_HZ = 22_000;
  localparam int H = (CLK_HZ / TONE_HZ + 1) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic tone_on = 1'b0;
  logic key_in = 1'b0;
  logic tone_out;
  logic tone_active;

  int checks = 0;
  int errors = 0;
  string cur_req = "R7";
  bit finished = 1'b0;
  bit noise = 1'b0;
  bit [7:0] lfsr = 8'hA5;

  always #5 clk = ~clk;

  tone_carrier_top #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ)) i_tone_carrier_top (
    .clk(clk), .rst_n(rst_n), .en(en), .tone_on(tone_on), .key_in(key_in),
    .tone_out(tone_out), .tone_active(tone_active)
  );

  // Behavioural reference: key history queue, remaining-cycle counter.
  bit hist[$];
  bit m_on = 0, m_lvl = 0;
  int m_left = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0, 0, 0};
      m_on = 0; m_lvl = 0; m_left = 0;
    end else begin
      bit ks, kq, want, rise;
      hist.push_front(key_in);
      void'(hist.pop_back());
      ks = hist[2];
      kq = hist[3];
      want = en && (tone_on || ks);
      rise = ks && !kq;
      if (!en) begin
        m_on = 0; m_lvl = 0; m_left = 0;
      end else if (want && (!m_on || (rise && !tone_on))) begin
        m_on = 1; m_lvl = 1; m_left = H;
      end else if (m_on) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          if (want) begin m_lvl = !m_lvl; m_left = H; end
          else begin m_on = 0; m_lvl = 0; end
        end
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Per-clock comparison against the model, plus a rising-edge counter.
  int rise_cnt = 0;
  logic prev_out = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(cur_req, "tone_out vs model", int'(tone_out), int'(m_lvl));
      check(cur_req, "tone_active vs model", int'(tone_active), int'(m_on));
      if (tone_out && !prev_out) rise_cnt++;
    end
    prev_out = tone_out;
    if (noise) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      key_in = lfsr[0];
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Measures one full high half and one low half of a running carrier.
  task automatic measure_halves(string req);
    int hi = 0, lo = 0;
    while (tone_out) @(negedge clk);
    while (!tone_out) @(negedge clk);
    while (tone_out) begin hi++; @(negedge clk); end
    while (!tone_out) begin lo++; @(negedge clk); end
    check(req, "high half length", hi, H);
    check(req, "low half length", lo, H);
  endtask

  task automatic keyed_burst(int w, string req);
    int lat = 0;
    @(negedge clk);
    rise_cnt = 0;
    key_in = 1'b1;
    while (!tone_out && lat < 10) begin @(negedge clk); lat++; end
    check("R3", "start latency in edges", lat, 3);
    idle(w - lat);
    key_in = 1'b0;
    idle(3 * H + 10);
    check(req, "rising edges in burst", rise_cnt, (w + 2 * H - 1) / (2 * H));
    check(req, "idle after burst", int'(tone_active), 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R7: reset state
    idle(3);
    check("R7", "tone_out in reset", int'(tone_out), 0);
    check("R7", "tone_active in reset", int'(tone_active), 0);
    rst_n = 1'b1;
    idle(2);
    check("R7", "tone_out after reset", int'(tone_out), 0);

    // R5: standby ignores key and tone_on
    cur_req = "R5";
    tone_on = 1'b1;
    key_in = 1'b1;
    idle(3 * H);
    check("R5", "no tone in standby", int'(tone_active), 0);
    tone_on = 1'b0;
    key_in = 1'b0;
    idle(5);

    // R2 / R1: continuous tone with noisy key
    cur_req = "R2";
    en = 1'b1;
    tone_on = 1'b1;
    noise = 1'b1;
    idle(2);
    measure_halves("R1");
    measure_halves("R2");
    idle(7 * H);
    check("R2", "continuous still active", int'(tone_active), 1);
    noise = 1'b0;
    key_in = 1'b0;
    tone_on = 1'b0;
    idle(3 * H);
    check("R4", "stopped after tone_on clear", int'(tone_active), 0);

    // R3 / R4: keyed bursts of several widths
    cur_req = "R4";
    keyed_burst(4 * H, "R4");
    keyed_burst(5 * H, "R4");
    keyed_burst(7 * H, "R4");
    keyed_burst(2 * H, "R3");

    // R6: re-key while the carrier is finishing a half
    cur_req = "R6";
    key_in = 1'b1;
    idle(H + H / 2);
    key_in = 1'b0;
    idle(3);
    key_in = 1'b1;
    idle(4);
    check("R6", "high right after re-key", int'(tone_out), 1);
    begin
      int hi = 0;
      while (tone_out) begin hi++; @(negedge clk); end
      check("R6", "restarted high half length", hi + 1, H);
    end
    key_in = 1'b0;
    idle(3 * H);

    // R5: enable drop mid-tone
    cur_req = "R5";
    tone_on = 1'b1;
    idle(H + 3);
    en = 1'b0;
    @(negedge clk);
    check("R5", "off one edge after en low", int'(tone_active), 0);
    check("R8", "out low while inactive", int'(tone_out), 0);
    idle(2 * H);
    tone_on = 1'b0;
    idle(4);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule